// File: doc/BRIEF.md
# Flash Cache-Program Controller

This block models the device side of a NAND-style flash during cache programming. The host presents bus cycles, each tagged as a command, an address or a data byte. A program sequence opens with a setup command, then a fixed number of address bytes, then page data. A commit command hands the page from the cache register to the page buffer. The block then runs a timed array program on the page buffer. While that program runs, the host can stream the next page into the cache.

Two busy conditions are tracked separately. The cache register stays busy from a commit until its contents reach the page buffer. A page can only be moved once the array is free. The array stays busy for a parameterised program time after each move. A ready/busy pin and a readable status byte expose both conditions. The status byte also keeps an error flag for the page just finished and one for the page before it. Program failures come from a test input, and the array contents are not modelled.

Top module: `fcp_cache_prog`

## Requirements
- R1: After reset `rb_n` is 1 and `io_out` is 0, and a status read returns 8'h60.
- R2: A command cycle (`bus_kind` 0) of 8'h70 makes `io_out` show the status byte from the following cycles on: bit 6 = cache ready, bit 5 = array idle with no page waiting or moving, bit 1 = previous-page error, bit 0 = current-page error, other bits 0. Any other command returns `io_out` to 0. Address cycles (`bus_kind` 1) and data cycles (`bus_kind` 2) leave the status view unchanged.
- R3: The sequence 8'h80, then ADDR_CYCLES address cycles, then data, then 8'h15 commits a page. `rb_n` goes low, then returns high once the page reaches the page buffer, while the array still programs (status 8'h40).
- R4: A committed page leaves the cache only after the running array program ends. `rb_n` stays low for the whole wait.
- R5: A final commit 8'h10 keeps `rb_n` low until the queued move and all array programming are finished.
- R6: Each finished array program moves bit 0 into bit 1 and loads bit 0 with the `fail_in` value sampled when that page entered the page buffer.
- R7: A commit whose block (row address above the low PAGE_BITS bits; the first row byte is the least significant) differs from the first page's block aborts the operation. It sets bit 0 and leaves `rb_n` high.
- R8: Up to PAGES_MAX pages commit in one operation; one more aborts and sets bit 0.
- R9: While `rb_n` is low, every bus cycle except command 8'h70 is ignored. A commit without an accepted setup and full address is also ignored.
- R10: The setup command that opens a new operation clears bits 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_kind | input | 2 | 0 command, 1 address, 2 data |
| bus_data | input | 8 | Byte carried by the bus cycle |
| fail_in | input | 1 | Injected program failure for the page entering the page buffer |
| io_out | output | 8 | Status byte in status view, else 0 |
| rb_n | output | 1 | Ready (1) / busy (0) |

## Verification
The bench commits a second page while the first is still programming. A design that moved the page too early would raise ready/busy after the short move time. A final commit is checked at a point where the cache is empty but the array still runs, so a controller that forgot the final hold releases the pin there. A failing page is followed by a clean one to prove that the error flags shift into the previous-page bit rather than overwrite it. Stray setup and address cycles sent during busy are followed by a bare commit, which would start a program if they had been taken. The block crossing and the sixty-fifth page are both checked for an abort that never drops ready/busy.

// File: rtl/fcp_pkg.sv
package fcp_pkg;
  typedef enum logic [1:0] {
    BK_CMD  = 2'd0,
    BK_ADDR = 2'd1,
    BK_DATA = 2'd2,
    BK_NONE = 2'd3
  } bus_kind_e;

  localparam logic [7:0] OP_SETUP    = 8'h80;
  localparam logic [7:0] OP_CACHE_GO = 8'h15;
  localparam logic [7:0] OP_LAST_GO  = 8'h10;
  localparam logic [7:0] OP_STATUS   = 8'h70;

  localparam int SB_CUR   = 0;
  localparam int SB_PREV  = 1;
  localparam int SB_ARR   = 5;
  localparam int SB_CACHE = 6;
endpackage

// File: rtl/fcp_cmd_decode.sv
module fcp_cmd_decode
  import fcp_pkg::*;
#(
  parameter int ADDR_CYCLES = 5,
  parameter int COL_CYCLES  = 2,
  parameter int PAGE_BITS   = 6,
  parameter int PAGES_MAX   = 64,
  parameter int PAGE_BYTES  = 2112
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_valid,
  input  logic [1:0] bus_kind,
  input  logic [7:0] bus_data,
  input  logic       accept,
  output logic       page_go,
  output logic       last_go,
  output logic       abort,
  output logic       op_start,
  output logic       stat_mode
);
  localparam int ROW_W  = 8 * (ADDR_CYCLES - COL_CYCLES);
  localparam int ACNT_W = $clog2(ADDR_CYCLES + 1);
  localparam int PCNT_W = $clog2(PAGES_MAX + 1);
  localparam int BCNT_W = $clog2(PAGE_BYTES + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_DATA} phase_e;

  phase_e                    phase_q;
  logic [ACNT_W-1:0]         acnt_q;
  logic [BCNT_W-1:0]         bcnt_q;
  logic [ROW_W-1:0]          row_q;
  logic [ROW_W-PAGE_BITS-1:0] op_blk_q;
  logic [PCNT_W-1:0]         pages_q;
  logic                      op_active_q;
  logic                      take;
  logic                      is_cmd, is_commit, over_limit;

  assign is_cmd     = bus_valid && (bus_kind == BK_CMD);
  assign take       = bus_valid && (accept || (is_cmd && bus_data == OP_STATUS));
  assign is_commit  = (bus_data == OP_CACHE_GO) || (bus_data == OP_LAST_GO);
  assign over_limit = (pages_q == PCNT_W'(PAGES_MAX)) ||
                      ((pages_q != '0) && (row_q[ROW_W-1:PAGE_BITS] != op_blk_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q     <= PH_IDLE;
      acnt_q      <= '0;
      bcnt_q      <= '0;
      row_q       <= '0;
      op_blk_q    <= '0;
      pages_q     <= '0;
      op_active_q <= 1'b0;
      stat_mode   <= 1'b0;
      page_go     <= 1'b0;
      last_go     <= 1'b0;
      abort       <= 1'b0;
      op_start    <= 1'b0;
    end else begin
      page_go  <= 1'b0;
      last_go  <= 1'b0;
      abort    <= 1'b0;
      op_start <= 1'b0;
      if (take) begin
        unique case (bus_kind)
          BK_CMD: begin
            stat_mode <= (bus_data == OP_STATUS);
            if (bus_data == OP_SETUP) begin
              phase_q <= PH_ADDR;
              acnt_q  <= '0;
              bcnt_q  <= '0;
              row_q   <= '0;
              if (!op_active_q) begin
                op_active_q <= 1'b1;
                pages_q     <= '0;
                op_start    <= 1'b1;
              end
            end else if (is_commit && phase_q == PH_DATA) begin
              phase_q <= PH_IDLE;
              if (over_limit) begin
                abort       <= 1'b1;
                op_active_q <= 1'b0;
              end else begin
                pages_q <= pages_q + 1'b1;
                if (pages_q == '0) op_blk_q <= row_q[ROW_W-1:PAGE_BITS];
                if (bus_data == OP_LAST_GO) begin
                  last_go     <= 1'b1;
                  op_active_q <= 1'b0;
                end else begin
                  page_go <= 1'b1;
                end
              end
            end
          end
          BK_ADDR: begin
            if (phase_q == PH_ADDR) begin
              if (acnt_q >= ACNT_W'(COL_CYCLES)) row_q <= {bus_data, row_q[ROW_W-1:8]};
              acnt_q <= acnt_q + 1'b1;
              if (acnt_q == ACNT_W'(ADDR_CYCLES - 1)) phase_q <= PH_DATA;
            end
          end
          BK_DATA: begin
            if (phase_q == PH_DATA && bcnt_q < BCNT_W'(PAGE_BYTES)) bcnt_q <= bcnt_q + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // R8
  pages_cap_chk: assert property (@(posedge clk) disable iff (rst)
    pages_q <= PCNT_W'(PAGES_MAX));

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !accept) |=> !page_go && !last_go && !abort && !op_start);
endmodule

// File: rtl/fcp_cache_ctrl.sv
module fcp_cache_ctrl #(
  parameter int XFER_CYCLES = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic commit,
  input  logic arr_idle,
  output logic cache_busy,
  output logic moving,
  output logic move_done
);
  localparam int XC_W = $clog2(XFER_CYCLES + 1);

  typedef enum logic [1:0] {C_FREE, C_WAIT, C_MOVE} cstate_e;

  cstate_e         state_q;
  logic [XC_W-1:0] cnt_q;

  assign cache_busy = (state_q != C_FREE);
  assign moving     = (state_q == C_MOVE);
  assign move_done  = moving && (cnt_q == XC_W'(XFER_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= C_FREE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        C_FREE: if (commit) state_q <= C_WAIT;
        C_WAIT: if (arr_idle) begin
          state_q <= C_MOVE;
          cnt_q   <= '0;
        end
        C_MOVE: begin
          if (move_done) state_q <= C_FREE;
          else           cnt_q   <= cnt_q + 1'b1;
        end
        default: state_q <= C_FREE;
      endcase
    end
  end

  // R4
  wait_for_array_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == C_WAIT && !arr_idle) |=> (state_q == C_WAIT));
endmodule

// File: rtl/fcp_array_prog.sv
module fcp_array_prog #(
  parameter int PROG_CYCLES = 300
) (
  input  logic clk,
  input  logic rst,
  input  logic move_done,
  input  logic fail_in,
  input  logic op_start,
  input  logic abort,
  output logic arr_idle,
  output logic err_prev,
  output logic err_cur
);
  localparam int PC_W = $clog2(PROG_CYCLES + 1);

  logic            busy_q, fail_q;
  logic [PC_W-1:0] cnt_q;
  logic            finish;

  assign arr_idle = !busy_q;
  assign finish   = busy_q && (cnt_q == PC_W'(PROG_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      fail_q   <= 1'b0;
      cnt_q    <= '0;
      err_prev <= 1'b0;
      err_cur  <= 1'b0;
    end else begin
      if (move_done) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        fail_q <= fail_in;
      end else if (finish) begin
        busy_q   <= 1'b0;
        err_prev <= err_cur;
        err_cur  <= fail_q;
      end else if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (op_start) begin
        err_prev <= 1'b0;
        err_cur  <= 1'b0;
      end
      if (abort) err_cur <= 1'b1;
    end
  end

  // R6
  err_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (finish && !op_start && !abort) |=> (err_prev == $past(err_cur)));
endmodule

// File: rtl/fcp_cache_prog.sv
module fcp_cache_prog
  import fcp_pkg::*;
#(
  parameter int ADDR_CYCLES = 5,
  parameter int COL_CYCLES  = 2,
  parameter int PAGE_BITS   = 6,
  parameter int PAGES_MAX   = 64,
  parameter int PAGE_BYTES  = 2112,
  parameter int XFER_CYCLES = 25,
  parameter int PROG_CYCLES = 300
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_valid,
  input  logic [1:0] bus_kind,
  input  logic [7:0] bus_data,
  input  logic       fail_in,
  output logic [7:0] io_out,
  output logic       rb_n
);
  logic page_go, last_go, abort, op_start, stat_mode;
  logic cache_busy, moving, move_done, arr_idle;
  logic err_prev, err_cur, final_q, accept;
  logic [7:0] status;

  assign accept = !cache_busy && !final_q && !page_go && !last_go;

  fcp_cmd_decode #(
    .ADDR_CYCLES(ADDR_CYCLES), .COL_CYCLES(COL_CYCLES), .PAGE_BITS(PAGE_BITS),
    .PAGES_MAX(PAGES_MAX), .PAGE_BYTES(PAGE_BYTES)
  ) u_decode (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_kind(bus_kind),
    .bus_data(bus_data), .accept(accept), .page_go(page_go), .last_go(last_go),
    .abort(abort), .op_start(op_start), .stat_mode(stat_mode)
  );

  fcp_cache_ctrl #(.XFER_CYCLES(XFER_CYCLES)) u_cache (
    .clk(clk), .rst(rst), .commit(page_go || last_go), .arr_idle(arr_idle),
    .cache_busy(cache_busy), .moving(moving), .move_done(move_done)
  );

  fcp_array_prog #(.PROG_CYCLES(PROG_CYCLES)) u_array (
    .clk(clk), .rst(rst), .move_done(move_done), .fail_in(fail_in),
    .op_start(op_start), .abort(abort), .arr_idle(arr_idle),
    .err_prev(err_prev), .err_cur(err_cur)
  );

  always_comb begin
    status           = '0;
    status[SB_CACHE] = !cache_busy;
    status[SB_ARR]   = arr_idle && !cache_busy;
    status[SB_PREV]  = err_prev;
    status[SB_CUR]   = err_cur;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      final_q <= 1'b0;
      rb_n    <= 1'b1;
      io_out  <= '0;
    end else begin
      if (last_go)                       final_q <= 1'b1;
      else if (!cache_busy && arr_idle)  final_q <= 1'b0;
      rb_n   <= !(cache_busy || final_q || page_go || last_go);
      io_out <= stat_mode ? status : 8'h00;
    end
  end

  // R4
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    moving |-> arr_idle);

  // R3
  busy_rb_chk: assert property (@(posedge clk) disable iff (rst)
    cache_busy |=> !rb_n);

  // R5
  final_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (final_q && !arr_idle) |=> !rb_n);
endmodule

// File: tb/test_fcp_cache_prog.sv
module test_fcp_cache_prog;
  localparam int CLK_PERIOD = 10;
  localparam int XFER = 4;
  localparam int PROG = 60;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_valid = 1'b0;
  logic [1:0] bus_kind = 2'd3;
  logic [7:0] bus_data = '0;
  logic       fail_in = 1'b0;
  logic [7:0] io_out;
  logic       rb_n;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic       use_io;
    logic [7:0] io;
    logic       rb;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fcp_cache_prog #(.PAGE_BYTES(16), .XFER_CYCLES(XFER), .PROG_CYCLES(PROG)) i_fcp_cache_prog (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_kind(bus_kind),
    .bus_data(bus_data), .fail_in(fail_in), .io_out(io_out), .rb_n(rb_n)
  );

  // monitor: pops one expectation per falling edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (e.use_io && io_out !== e.io) begin
        fails++;
        $display("FAIL %s io_out actual %h expected %h", e.tag, io_out, e.io);
      end else if (!e.use_io && rb_n !== e.rb) begin
        fails++;
        $display("FAIL %s rb_n actual %b expected %b", e.tag, rb_n, e.rb);
      end
    end
  end

  task automatic push_exp(input logic use_io, input logic [7:0] io, input logic rb, input string tag);
    exp_t e;
    @(posedge clk); #1;
    e.use_io = use_io; e.io = io; e.rb = rb; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
  endtask

  task automatic bus_cyc(input logic [1:0] k, input logic [7:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_kind = k; bus_data = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_kind = 2'd3;
  endtask

  task automatic read_status(input logic [7:0] exp, input string tag);
    bus_cyc(2'd0, 8'h70);
    push_exp(1'b1, exp, 1'b0, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_ready(input string tag);
    int n = 0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    while (rb_n !== 1'b1 && n < 2000) begin
      @(negedge clk); n++;
    end
    if (n >= 2000) begin
      checks++; fails++;
      $display("FAIL %s rb_n actual %b expected 1 (never ready)", tag, rb_n);
    end
  endtask

  task automatic send_addr(input int blk, input int pg);
    logic [23:0] row;
    row = 24'((blk << 6) | pg);
    bus_cyc(2'd0, 8'h80);
    bus_cyc(2'd1, 8'h00);
    bus_cyc(2'd1, 8'h00);
    bus_cyc(2'd1, row[7:0]);
    bus_cyc(2'd1, row[15:8]);
    bus_cyc(2'd1, row[23:16]);
  endtask

  task automatic send_page(input int blk, input int pg, input int nb, input logic [7:0] conf);
    send_addr(blk, pg);
    for (int i = 0; i < nb; i++) bus_cyc(2'd2, 8'(i + 7));
    bus_cyc(2'd0, conf);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    // R1 reset state
    push_exp(1'b1, 8'h00, 1'b0, "R1 io after reset");
    push_exp(1'b0, 8'h00, 1'b1, "R1 rb after reset");
    read_status(8'h60, "R1 R2 status after reset");

    // R3 single cache commit
    send_page(0, 0, 4, 8'h15);
    push_exp(1'b0, 8'h00, 1'b0, "R3 busy after commit");
    wait_ready("R3 ready");
    read_status(8'h40, "R3 cache free, array programming");
    idle(PROG + 10);
    read_status(8'h60, "R2 status after program done");
    bus_cyc(2'd0, 8'hFF);
    push_exp(1'b1, 8'h00, 1'b0, "R2 status view left");

    // R4 second page waits for the array; R9 stray cycles during busy
    send_page(0, 1, 2, 8'h15);
    wait_ready("R4 first ready");
    send_page(0, 2, 2, 8'h15);
    idle(10);
    push_exp(1'b0, 8'h00, 1'b0, "R4 held busy while array runs");
    send_addr(3, 0);
    wait_ready("R4 second ready");
    bus_cyc(2'd2, 8'h11);
    bus_cyc(2'd2, 8'h22);
    bus_cyc(2'd0, 8'h15);
    idle(4);
    push_exp(1'b0, 8'h00, 1'b1, "R9 stray commit ignored");
    idle(PROG + 20);
    read_status(8'h60, "R9 no abort from stray cycles");

    // R5 R6 final commit and error shifting
    fail_in = 1'b1;
    send_page(0, 3, 2, 8'h15);
    wait_ready("R6 failing page moved");
    fail_in = 1'b0;
    send_page(0, 4, 2, 8'h10);
    idle(60);
    push_exp(1'b0, 8'h00, 1'b0, "R5 held busy until array done");
    wait_ready("R5 final ready");
    read_status(8'h62, "R5 R6 error moved to previous");

    // R10 new operation clears errors
    send_addr(0, 0);
    read_status(8'h60, "R10 errors cleared on new op");
    bus_cyc(2'd2, 8'h01);
    bus_cyc(2'd0, 8'h10);
    wait_ready("R10 ready");

    // R7 block crossing
    send_page(0, 5, 2, 8'h15);
    wait_ready("R7 first ready");
    idle(PROG + 20);
    send_page(1, 0, 2, 8'h10);
    idle(2);
    push_exp(1'b0, 8'h00, 1'b1, "R7 abort keeps ready");
    read_status(8'h61, "R7 abort sets current error");

    // R8 page limit
    for (int i = 0; i < 64; i++) begin
      send_page(2, i, 1, 8'h15);
      wait_ready("R8 page ready");
    end
    idle(PROG + 20);
    read_status(8'h60, "R8 sixty-four pages accepted");
    send_page(2, 1, 1, 8'h15);
    idle(2);
    push_exp(1'b0, 8'h00, 1'b1, "R8 extra page keeps ready");
    read_status(8'h61, "R8 extra page aborts");

    idle(5);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule